// File: doc/BRIEF.md
# GPIO Edge Detect and Interrupt Aggregator

This block watches a set of general-purpose pins, grouped in banks of 32, and turns enabled level transitions into sticky per-pin event flags. Software picks, pin by pin, whether a 0-to-1 change, a 1-to-0 change, both or neither should latch an event. It does this through two enable registers per bank. Events are only taken from pins that the direction input marks as inputs. Software reads the event flags and acknowledges them by writing ones to the status register. The flags are folded into three level interrupts. Pin 0 and pin 1 of the first bank each have a line of their own, and every other pin shares a third line.

A second path serves low-power states. While the halted flag is high, any level change on an input pin that belongs to its bank's fixed wake set produces a one-cycle wake pulse. The enable registers have no effect on this path.

Register access uses a plain single-cycle write strobe and a combinational read port. Both are control paths with no back-pressure: a write is taken on every clock edge where the strobe is high, and read data reflects the addressed register in the same cycle. Pin levels pass through a two-flop synchronizer inside the block.

Top module: `gpio_edge_irq_top`

## Requirements
- R1: A status bit becomes 1 when its rising-enable bit is 1, its direction bit is 0 (input), and the synchronized level goes from 0 to 1. With the enable bit at 0, a rising change leaves the status bit unchanged.
- R2: A status bit becomes 1 when its falling-enable bit is 1, its direction bit is 0, and the synchronized level goes from 1 to 0.
- R3: A write to a bank's status address clears exactly the bits where the write data is 1. All other status bits keep their value.
- R4: A pin whose direction bit is 1 (output) never sets its status bit, whatever its level does.
- R5: `irq_pin0_o` equals status bit 0 of bank 0, and `irq_pin1_o` equals status bit 1 of bank 0.
- R6: `irq_shared_o` is the OR of bank 0 status bits 31..2 and all status bits of every other bank.
- R7: Register addresses per bank 0,1,2,3 are as follows. Rising enable: 0x030, 0x034, 0x038, 0x130. Falling enable: 0x03C, 0x040, 0x044, 0x13C. Status: 0x048, 0x04C, 0x050, 0x148. All three read back through `rd_data_o`, any other address reads 0, and writes to other addresses change nothing.
- R8: `wake_o` pulses high for one cycle when `halted_i` is 1 and a synchronized level change occurs on an input pin that is in its bank's wake set. The wake sets for banks 0..3 are 0x8003FE1B, 0x002001FC, 0xEC080000 and 0x0012007F. A change outside those conditions gives no pulse.
- R9: If a status bit is set by an event in the same cycle that a clear write targets it, the bit ends up 1.
- R10: Suppose a pin changes before clock edge k. Its status bit and any wake pulse become visible after edge k+2, and not after edge k+1.
- R11: After reset all enables and status bits are 0, all interrupts are low and `wake_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_BANKS*BANK_W | Raw pin levels, bank b at bits [b*BANK_W +: BANK_W] |
| dir_i | input | NUM_BANKS*BANK_W | Direction per pin, 1 = output, 0 = input |
| halted_i | input | 1 | System halted flag, enables wake detection |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | BANK_W | Register write data |
| rd_addr_i | input | ADDR_W | Register read address |
| rd_data_o | output | BANK_W | Read data for `rd_addr_i` |
| irq_pin0_o | output | 1 | Interrupt for bank 0 pin 0 |
| irq_pin1_o | output | 1 | Interrupt for bank 0 pin 1 |
| irq_shared_o | output | 1 | Interrupt for all remaining pins |
| wake_o | output | 1 | One-cycle wake request |

## Verification
The bench builds the block with its defaults: four banks of 32 pins and a 9-bit address. This puts the fourth bank, which lives in the upper address page at 0x100, within reach of the tests, along with the fixed wake sets of all four banks and the split between the two dedicated interrupt lines and the shared one. A behavioural model steps through synchronizer, event, clear and wake behaviour every cycle. Directed sequences target the three-edge latency, clear/set collisions, output-pin suppression and wake gating by halt, mask and direction.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  // Register base offsets for the first bank; banks advance by 4 bytes
  localparam int RISE_BASE  = 'h030;
  localparam int FALL_BASE  = 'h03C;
  localparam int STAT_BASE  = 'h048;
  // Banks beyond the low group live in the upper address page
  localparam int HIGH_PAGE  = 'h100;
  localparam int BANK_STEP  = 4;

  function automatic int reg_addr(input int base, input int bank, input int low_banks);
    if (bank < low_banks) return base + BANK_STEP * bank;
    return HIGH_PAGE + base + BANK_STEP * (bank - low_banks);
  endfunction

  // Fixed set of pins per bank that may wake a halted system
  function automatic logic [31:0] wake_set(input int bank);
    case (bank)
      0:       return 32'h8003_FE1B;
      1:       return 32'h0020_01FC;
      2:       return 32'hEC08_0000;
      3:       return 32'h0012_007F;
      default: return 32'h0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] prev_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] level_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= '0;
      level_q <= '0;
      prev_q  <= '0;
    end else begin
      meta_q  <= pin_i;
      level_q <= meta_q;
      prev_q  <= level_q;
    end
  end

  assign level_o = level_q;
  assign prev_o  = prev_q;

endmodule

// File: rtl/gpio_bank_edge.sv
module gpio_bank_edge #(
  parameter int           W         = 32,
  parameter logic [W-1:0] WAKE_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] dir_i,
  input  logic         halted_i,
  input  logic         rise_we_i,
  input  logic         fall_we_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o,
  output logic [W-1:0] status_o,
  output logic         wake_hit_o
);

  logic [W-1:0] rise_q, fall_q, status_q;
  logic [W-1:0] is_input, changed, up_evt, down_evt, set_vec, clr_mask;

  always_comb begin
    is_input = ~dir_i;
    changed  = level_i ^ prev_i;
    up_evt   = rise_q & level_i & ~prev_i;
    down_evt = fall_q & ~level_i & prev_i;
    set_vec  = is_input & (up_evt | down_evt);
    clr_mask = clr_we_i ? wdata_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q   <= '0;
      fall_q   <= '0;
      status_q <= '0;
    end else begin
      if (rise_we_i) rise_q <= wdata_i;
      if (fall_we_i) fall_q <= wdata_i;
      // a set event outranks a simultaneous clear
      status_q <= (status_q & ~clr_mask) | set_vec;
    end
  end

  assign wake_hit_o = halted_i & (|(changed & is_input & WAKE_MASK));
  assign rise_o     = rise_q;
  assign fall_o     = fall_q;
  assign status_o   = status_q;

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status_q) & ~$past(clr_mask)) & ~status_q) == '0)) // R3
    else $error("status bit dropped without clear");

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we_i |=> ((status_q & $past(wdata_i) & ~$past(~dir_i & (level_i ^ prev_i))) == '0)) // R3
    else $error("cleared bit still set");

  AST_SET_NEEDS_INPUT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(~dir_i & (level_i ^ prev_i))) == '0)) // R4
    else $error("status set without an input-pin change");

endmodule

// File: rtl/gpio_irq_combine.sv
module gpio_irq_combine #(
  parameter int NB = 4,
  parameter int BW = 32
) (
  input  logic [NB*BW-1:0] status_i,
  output logic             irq0_o,
  output logic             irq1_o,
  output logic             shared_o
);

  assign irq0_o   = status_i[0];
  assign irq1_o   = status_i[1];
  assign shared_o = |status_i[NB*BW-1:2];

endmodule

// File: rtl/gpio_edge_irq_top.sv
module gpio_edge_irq_top #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 9,
  parameter int LOW_BANKS = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0] pin_i,
  input  logic [NUM_BANKS*BANK_W-1:0] dir_i,
  input  logic                        halted_i,
  input  logic                        wr_en_i,
  input  logic [ADDR_W-1:0]           wr_addr_i,
  input  logic [BANK_W-1:0]           wr_data_i,
  input  logic [ADDR_W-1:0]           rd_addr_i,
  output logic [BANK_W-1:0]           rd_data_o,
  output logic                        irq_pin0_o,
  output logic                        irq_pin1_o,
  output logic                        irq_shared_o,
  output logic                        wake_o
);
  import gpio_edge_pkg::*;

  localparam int PIN_W = NUM_BANKS * BANK_W;

  logic [PIN_W-1:0]     level_v, prev_v, status_flat;
  logic [BANK_W-1:0]    rise_v [NUM_BANKS];
  logic [BANK_W-1:0]    fall_v [NUM_BANKS];
  logic [BANK_W-1:0]    stat_v [NUM_BANKS];
  logic [NUM_BANKS-1:0] wake_hits;
  logic                 wake_q;

  gpio_pin_sync #(.W(PIN_W)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_i   (pin_i),
    .level_o (level_v),
    .prev_o  (prev_v)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] A_RISE = ADDR_W'(reg_addr(RISE_BASE, b, LOW_BANKS));
    localparam logic [ADDR_W-1:0] A_FALL = ADDR_W'(reg_addr(FALL_BASE, b, LOW_BANKS));
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(reg_addr(STAT_BASE, b, LOW_BANKS));
    localparam logic [BANK_W-1:0] MASK   = BANK_W'(wake_set(b));

    logic rise_we, fall_we, clr_we;
    assign rise_we = wr_en_i && (wr_addr_i == A_RISE);
    assign fall_we = wr_en_i && (wr_addr_i == A_FALL);
    assign clr_we  = wr_en_i && (wr_addr_i == A_STAT);

    gpio_bank_edge #(.W(BANK_W), .WAKE_MASK(MASK)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .level_i    (level_v[b*BANK_W +: BANK_W]),
      .prev_i     (prev_v[b*BANK_W +: BANK_W]),
      .dir_i      (dir_i[b*BANK_W +: BANK_W]),
      .halted_i   (halted_i),
      .rise_we_i  (rise_we),
      .fall_we_i  (fall_we),
      .clr_we_i   (clr_we),
      .wdata_i    (wr_data_i),
      .rise_o     (rise_v[b]),
      .fall_o     (fall_v[b]),
      .status_o   (stat_v[b]),
      .wake_hit_o (wake_hits[b])
    );

    assign status_flat[b*BANK_W +: BANK_W] = stat_v[b];
  end

  always_comb begin
    rd_data_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (rd_addr_i == ADDR_W'(reg_addr(RISE_BASE, b, LOW_BANKS))) rd_data_o = rise_v[b];
      if (rd_addr_i == ADDR_W'(reg_addr(FALL_BASE, b, LOW_BANKS))) rd_data_o = fall_v[b];
      if (rd_addr_i == ADDR_W'(reg_addr(STAT_BASE, b, LOW_BANKS))) rd_data_o = stat_v[b];
    end
  end

  gpio_irq_combine #(.NB(NUM_BANKS), .BW(BANK_W)) u_irq (
    .status_i (status_flat),
    .irq0_o   (irq_pin0_o),
    .irq1_o   (irq_pin1_o),
    .shared_o (irq_shared_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= |wake_hits;
  end

  assign wake_o = wake_q;

  AST_WAKE_NEEDS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> $past(halted_i)) // R8
    else $error("wake without halt");

endmodule

// File: tb/sim_gpio_edge_irq_top.sv
`timescale 1ns/1ps
module sim_gpio_edge_irq_top;
  localparam int NB = 4;
  localparam int BW = 32;
  localparam int AW = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NB*BW-1:0] pins = '0;
  logic [NB*BW-1:0] dirs = '0;
  logic          halted = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [BW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [BW-1:0] rd_data;
  logic          irq0, irq1, irqs, wake;

  int tests = 0;
  int fails = 0;
  bit cmp_on = 1'b0;

  always #10 clk = ~clk;

  gpio_edge_irq_top u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .dir_i(dirs), .halted_i(halted),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .irq_pin0_o(irq0), .irq_pin1_o(irq1), .irq_shared_o(irqs), .wake_o(wake)
  );

  // ---------------- behavioural reference model ----------------
  int a_rise [NB] = '{'h030, 'h034, 'h038, 'h130};
  int a_fall [NB] = '{'h03C, 'h040, 'h044, 'h13C};
  int a_stat [NB] = '{'h048, 'h04C, 'h050, 'h148};
  logic [31:0] wmask [NB] = '{32'h8003FE1B, 32'h002001FC, 32'hEC080000, 32'h0012007F};

  logic [31:0] m_s1 [NB], m_s2 [NB], m_prev [NB];
  logic [31:0] m_rise [NB], m_fall [NB], m_stat [NB];
  bit m_wake;

  initial begin
    for (int b = 0; b < NB; b++) begin
      m_s1[b] = 0; m_s2[b] = 0; m_prev[b] = 0;
      m_rise[b] = 0; m_fall[b] = 0; m_stat[b] = 0;
    end
    m_wake = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) begin
        m_s1[b] = 0; m_s2[b] = 0; m_prev[b] = 0;
        m_rise[b] = 0; m_fall[b] = 0; m_stat[b] = 0;
      end
      m_wake = 0;
    end else begin
      bit wk;
      wk = 0;
      for (int b = 0; b < NB; b++) begin
        logic [31:0] din, nxt;
        din = ~dirs[b*BW +: BW];
        nxt = m_stat[b];
        if (wr_en && wr_addr == a_stat[b]) nxt = nxt & ~wr_data;
        for (int i = 0; i < 32; i++) begin
          if (din[i] && m_rise[b][i] && !m_prev[b][i] && m_s2[b][i]) nxt[i] = 1;
          if (din[i] && m_fall[b][i] && m_prev[b][i] && !m_s2[b][i]) nxt[i] = 1;
          if (halted && din[i] && wmask[b][i] && (m_prev[b][i] != m_s2[b][i])) wk = 1;
        end
        m_stat[b] = nxt;
        if (wr_en && wr_addr == a_rise[b]) m_rise[b] = wr_data;
        if (wr_en && wr_addr == a_fall[b]) m_fall[b] = wr_data;
        m_prev[b] = m_s2[b];
        m_s2[b]   = m_s1[b];
        m_s1[b]   = pins[b*BW +: BW];
      end
      m_wake = wk;
    end
  end

  function automatic logic [31:0] m_read(input logic [AW-1:0] a);
    for (int b = 0; b < NB; b++) begin
      if (a == a_rise[b]) return m_rise[b];
      if (a == a_fall[b]) return m_fall[b];
      if (a == a_stat[b]) return m_stat[b];
    end
    return 0;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // every-cycle comparison, away from the clock edge
  always @(negedge clk) begin
    #2;
    if (cmp_on && rst_n) begin
      logic sh;
      sh = ((m_stat[0] & 32'hFFFFFFFC) != 0) || (m_stat[1] != 0) || (m_stat[2] != 0) || (m_stat[3] != 0);
      chk("R5", "model irq0", {31'b0, irq0}, {31'b0, m_stat[0][0]});
      chk("R5", "model irq1", {31'b0, irq1}, {31'b0, m_stat[0][1]});
      chk("R6", "model shared", {31'b0, irqs}, {31'b0, sh});
      chk("R8", "model wake", {31'b0, wake}, {31'b0, m_wake});
      chk("R7", "model readback", rd_data, m_read(rd_addr));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1; wr_addr = AW'(a); wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
    rd_addr = AW'(a);
    #1;
    chk(req, "read", rd_data, exp);
  endtask

  // watchdog
  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1;
    #1;
    // R11 reset state
    chk("R11", "irq0", {31'b0, irq0}, 0);
    chk("R11", "irq1", {31'b0, irq1}, 0);
    chk("R11", "shared", {31'b0, irqs}, 0);
    chk("R11", "wake", {31'b0, wake}, 0);
    rd_chk("R11", 'h048, 0);
    rd_chk("R11", 'h130, 0);
    cmp_on = 1;

    // R7 register map and readback
    wr('h030, 32'h5);
    wr('h03C, 32'h2);
    wr('h1F0, 32'hFFFFFFFF);
    rd_chk("R7", 'h030, 32'h5);
    rd_chk("R7", 'h03C, 32'h2);
    rd_chk("R7", 'h1F0, 0);
    rd_chk("R7", 'h034, 0);

    // R10 latency and R1 rising edge on pin 0
    pins[0] = 1;
    tick(2);
    rd_chk("R10", 'h048, 0);
    tick();
    rd_chk("R1", 'h048, 32'h1);
    chk("R5", "irq0 after rise", {31'b0, irq0}, 1);

    // R1: rising on pin 1 without rising enable sets nothing
    pins[1] = 1;
    tick(4);
    rd_chk("R1", 'h048, 32'h1);
    // R2 falling on pin 1
    pins[1] = 0;
    tick(4);
    rd_chk("R2", 'h048, 32'h3);
    chk("R5", "irq1 after fall", {31'b0, irq1}, 1);

    // R3 write-one-to-clear
    wr('h048, 32'h1);
    rd_chk("R3", 'h048, 32'h2);
    chk("R3", "irq0 cleared", {31'b0, irq0}, 0);
    wr('h048, 32'h0);
    rd_chk("R3", 'h048, 32'h2);

    // R4 output pins never set status
    dirs[2] = 1;
    pins[2] = 1;
    tick(4);
    rd_chk("R4", 'h048, 32'h2);

    // R6 shared line from banks 2 and 3
    wr('h048, 32'h2);
    wr('h038, 32'h10);
    pins[64+4] = 1;
    tick(4);
    chk("R6", "shared bank2", {31'b0, irqs}, 1);
    rd_chk("R7", 'h050, 32'h10);
    wr('h050, 32'hFFFFFFFF);
    chk("R6", "shared cleared", {31'b0, irqs}, 0);
    wr('h130, 32'h1);
    pins[96] = 1;
    tick(4);
    rd_chk("R7", 'h148, 32'h1);
    chk("R6", "shared bank3", {31'b0, irqs}, 1);
    wr('h148, 32'h1);
    chk("R6", "shared cleared 3", {31'b0, irqs}, 0);

    // R9 set wins over simultaneous clear
    pins[0] = 0;
    tick(4);
    wr('h048, 32'hFFFFFFFF);
    rd_chk("R9", 'h048, 0);
    pins[0] = 1;
    tick(2);
    wr('h048, 32'h1);
    rd_chk("R9", 'h048, 32'h1);

    // R8 wake behaviour
    halted = 1;
    pins[0] = 0;
    tick(2);
    chk("R8", "wake early", {31'b0, wake}, 0);
    tick();
    chk("R8", "wake pulse", {31'b0, wake}, 1);
    tick();
    chk("R8", "wake ends", {31'b0, wake}, 0);
    dirs[2] = 0;
    tick(2);
    pins[2] = 0;        // bit 2 not in the bank 0 wake set
    tick(3);
    chk("R8", "no wake off-mask", {31'b0, wake}, 0);
    dirs[0] = 1;        // output pin in the mask
    pins[0] = 1;
    tick(3);
    chk("R8", "no wake output", {31'b0, wake}, 0);
    dirs[0] = 0;
    halted = 0;
    tick(2);
    pins[0] = 0;
    tick(3);
    chk("R8", "no wake unhalted", {31'b0, wake}, 0);
    tick(4);

    cmp_on = 0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule